// File: doc/BRIEF.md
# Pulse-Frequency Boost Switch Sequencer

This block is the digital timing core of a step-up converter that regulates by pulse frequency rather than pulse width. The analog side supplies three comparator flags: output feedback sitting below the reference, peak inductor current over its limit, and rectifier current near zero. A converter enable comes with them. From these flags the block drives three gates. The main low-side switch stores energy in the inductor. The synchronous rectifier passes that energy to the output. A damping switch quiets the ringing on the switch node once the inductor has run dry.

Every switching interval is a count of clock cycles. Three parameters set the limits: the longest allowed main on-time, the shortest allowed main off-time, and the break-before-make gap between the two power switches. When feedback stays low, the rectifier hands over straight to the next main pulse, which is continuous conduction. When feedback is satisfied, the rectifier conducts until the zero-current flag asserts. The damping switch then holds the node until the next request, which is discontinuous conduction. All four inputs pass through two-flop synchronizers. The three gates are driven from flops.

Top module: `pfm_boost_ctrl`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, all three gate outputs are low.
- R2: With `en` high and the block idle, a request on `fb_low` (1 = feedback below reference) raises `main_gate` at the third rising clock edge after the input changes. With no request, no gate rises.
- R3: With no current-limit trip, every main pulse lasts exactly `TON_CYC` cycles.
- R4: `ilim_trip` (1 = peak current exceeded) asserted while the main switch is on ends the pulse at the third rising edge after the input changes. If the flag is held high, each pulse lasts one cycle.
- R5: Between two main pulses, `main_gate` is low for at least `TOFF_CYC` cycles. Under a continuous request, it is low for exactly `TOFF_CYC` cycles.
- R6: `sync_gate` rises exactly `DEAD_CYC` cycles after `main_gate` falls.
- R7: Under a continuous request, `sync_gate` stays high for `TOFF_CYC - 2*DEAD_CYC` cycles. It then falls `DEAD_CYC` cycles before `main_gate` rises again.
- R8: `zero_cur` (1 = rectifier current near zero) asserted while the rectifier conducts drops `sync_gate` at the third rising edge after the input changes.
- R9: When `sync_gate` falls on a zero-current event, `damp_gate` rises on the same edge. It stays high while there is no request. It falls at the third edge after a new request arrives, and `main_gate` rises `DEAD_CYC` cycles later.
- R10: If `en` is low for three rising edges, all gates are low from the third edge onward, in every phase. When `en` returns, the block restarts from idle and never resumes a damping phase.
- R11: `main_gate` and `sync_gate` are never high together. `damp_gate` is never high with either of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Converter enable, asynchronous |
| fb_low | input | 1 | Feedback below reference, asynchronous |
| ilim_trip | input | 1 | Peak current limit flag, asynchronous |
| zero_cur | input | 1 | Rectifier zero-current flag, asynchronous |
| main_gate | output | 1 | Main switch drive, active high |
| sync_gate | output | 1 | Synchronous rectifier drive, active high |
| damp_gate | output | 1 | Damping switch drive, active high |

## Verification
A phase counter that loads wrongly shows up as a wrong pulse width or dead gap. The bench measures these in cycles on the first affected pulse, so the error is seen within one switching period. A wrong off-time count shows up as a rectifier width or main low time that differs from the arithmetic value. A wrong state transition shows up as two gates overlapping, or as damping that persists or returns after a request or shutdown. Overlaps are flagged in the same cycle. The other transition errors are flagged at the third edge after the stimulus.

// File: rtl/pfm_boost_pkg.sv
package pfm_boost_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_MAIN  = 3'd1,
        PH_GAP_A = 3'd2,
        PH_RECT  = 3'd3,
        PH_DAMP  = 3'd4,
        PH_GAP_B = 3'd5
    } phase_t;

    typedef struct packed {
        logic damp;
        logic rect;
        logic main;
    } drive_t;

    function automatic drive_t drive_of(phase_t p);
        drive_t d;
        d.main = (p == PH_MAIN);
        d.rect = (p == PH_RECT);
        d.damp = (p == PH_DAMP);
        return d;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pfm_sync.sv
module pfm_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta;
        logic stable;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta   <= 1'b0;
                stable <= 1'b0;
            end else begin
                meta   <= d[i];
                stable <= meta;
            end
        end
        assign q[i] = stable;
    end
endmodule

// File: rtl/pfm_offtimer.sv
module pfm_offtimer #(
    parameter int TOFF_CYC = 31,
    parameter int DEAD_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic main_on,
    output logic off_done,
    output logic rect_release
);
    localparam int CW = $clog2(TOFF_CYC + 1);
    localparam logic [CW-1:0] SAT = CW'(TOFF_CYC);
    localparam logic [CW-1:0] DONE_AT = CW'(TOFF_CYC - 1);
    localparam int REL_I = (TOFF_CYC > DEAD_CYC + 1) ? (TOFF_CYC - DEAD_CYC - 1) : 0;
    localparam logic [CW-1:0] REL_AT = CW'(REL_I);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= SAT;
        end else if (main_on) begin
            low_cnt <= '0;
        end else if (low_cnt != SAT) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign off_done     = (low_cnt >= DONE_AT);
    assign rect_release = (low_cnt >= REL_AT);
endmodule

// File: rtl/pfm_phase_fsm.sv
module pfm_phase_fsm
    import pfm_boost_pkg::*;
#(
    parameter int TON_CYC  = 140,
    parameter int DEAD_CYC = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  logic   req,
    input  logic   over_i,
    input  logic   zero_i,
    input  logic   off_done,
    input  logic   rect_release,
    output phase_t phase,
    output drive_t drive
);
    localparam int PMAX = max2(TON_CYC, DEAD_CYC);
    localparam int PW   = $clog2(PMAX + 1);
    localparam logic [PW-1:0] P_SAT     = PW'(PMAX);
    localparam logic [PW-1:0] TON_LAST  = PW'(TON_CYC - 1);
    localparam logic [PW-1:0] DEAD_LAST = PW'(DEAD_CYC - 1);

    phase_t        nxt;
    logic [PW-1:0] age;

    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_IDLE:  if (req && off_done) nxt = PH_MAIN;
            PH_MAIN:  if (over_i || age == TON_LAST) nxt = PH_GAP_A;
            PH_GAP_A: if (age >= DEAD_LAST) nxt = PH_RECT;
            PH_RECT: begin
                if (zero_i)                    nxt = PH_DAMP;
                else if (req && rect_release)  nxt = PH_GAP_B;
            end
            PH_DAMP:  if (req) nxt = PH_GAP_B;
            PH_GAP_B: if (age >= DEAD_LAST && off_done) nxt = PH_MAIN;
            default:  nxt = PH_IDLE;
        endcase
        if (!run) nxt = PH_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            age   <= '0;
            drive <= '0;
        end else begin
            phase <= nxt;
            drive <= drive_of(nxt);
            if (nxt != phase) begin
                age <= '0;
            end else if (age != P_SAT) begin
                age <= age + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pfm_boost_ctrl.sv
module pfm_boost_ctrl
    import pfm_boost_pkg::*;
#(
    parameter int TON_CYC  = 140,
    parameter int TOFF_CYC = 31,
    parameter int DEAD_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic fb_low,
    input  logic ilim_trip,
    input  logic zero_cur,
    output logic main_gate,
    output logic sync_gate,
    output logic damp_gate
);
    localparam int NIN = 4;

    logic [NIN-1:0] raw_in;
    logic [NIN-1:0] syn_in;
    logic           off_done;
    logic           rect_release;
    phase_t         phase;
    drive_t         drive;

    assign raw_in = {zero_cur, ilim_trip, fb_low, en};

    pfm_sync #(.W(NIN)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (syn_in)
    );

    pfm_offtimer #(.TOFF_CYC(TOFF_CYC), .DEAD_CYC(DEAD_CYC)) u_off (
        .clk          (clk),
        .rst          (rst),
        .main_on      (phase == PH_MAIN),
        .off_done     (off_done),
        .rect_release (rect_release)
    );

    pfm_phase_fsm #(.TON_CYC(TON_CYC), .DEAD_CYC(DEAD_CYC)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .run          (syn_in[0]),
        .req          (syn_in[1]),
        .over_i       (syn_in[2]),
        .zero_i       (syn_in[3]),
        .off_done     (off_done),
        .rect_release (rect_release),
        .phase        (phase),
        .drive        (drive)
    );

    assign main_gate = drive.main;
    assign sync_gate = drive.rect;
    assign damp_gate = drive.damp;
endmodule

// File: rtl/pfm_boost_chk.sv
module pfm_boost_chk #(
    parameter int TON_CYC  = 140,
    parameter int TOFF_CYC = 31,
    parameter int DEAD_CYC = 2
) (
    input logic clk,
    input logic rst,
    input logic en,
    input logic main_gate,
    input logic sync_gate,
    input logic damp_gate
);
    int   hi_run;
    int   lo_run;
    logic fell_once;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run    <= 0;
            lo_run    <= 0;
            fell_once <= 1'b0;
        end else begin
            hi_run <= main_gate ? ((hi_run < 1000000) ? hi_run + 1 : hi_run) : 0;
            lo_run <= main_gate ? 0 : ((lo_run < 1000000) ? lo_run + 1 : lo_run);
            if (!main_gate && hi_run != 0) fell_once <= 1'b1;
        end
    end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(main_gate && sync_gate)); // R11
    AST_DAMP_ALONE: assert property (@(posedge clk) disable iff (rst)
        damp_gate |-> (!main_gate && !sync_gate)); // R11
    AST_GAP_AFTER_MAIN: assert property (@(posedge clk) disable iff (rst)
        main_gate |=> !sync_gate); // R6
    AST_GAP_AFTER_RECT: assert property (@(posedge clk) disable iff (rst)
        sync_gate |=> !main_gate); // R7
    AST_ON_LIMIT: assert property (@(posedge clk) disable iff (rst)
        main_gate |-> (hi_run < TON_CYC)); // R3
    AST_OFF_LIMIT: assert property (@(posedge clk) disable iff (rst)
        ($rose(main_gate) && fell_once) |-> (lo_run >= TOFF_CYC)); // R5
    AST_SHUTDOWN: assert property (@(posedge clk) disable iff (rst)
        (!$past(en, 1) && !$past(en, 2) && !$past(en, 3)) |->
            (!main_gate && !sync_gate && !damp_gate)); // R10
endmodule

bind pfm_boost_ctrl pfm_boost_chk #(
    .TON_CYC  (TON_CYC),
    .TOFF_CYC (TOFF_CYC),
    .DEAD_CYC (DEAD_CYC)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .main_gate (main_gate),
    .sync_gate (sync_gate),
    .damp_gate (damp_gate)
);

// File: tb/pfm_boost_ctrl_tb.sv
module pfm_boost_ctrl_tb_top;
    localparam int TON  = 12;
    localparam int TOFF = 9;
    localparam int DEAD = 2;

    logic clk = 1'b0;
    logic rst, en, fb_low, ilim_trip, zero_cur;
    logic main_gate, sync_gate, damp_gate;
    int   checks = 0;
    int   errors = 0;
    int   overlap_seen = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    pfm_boost_ctrl #(.TON_CYC(TON), .TOFF_CYC(TOFF), .DEAD_CYC(DEAD)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .fb_low    (fb_low),
        .ilim_trip (ilim_trip),
        .zero_cur  (zero_cur),
        .main_gate (main_gate),
        .sync_gate (sync_gate),
        .damp_gate (damp_gate)
    );

    function automatic logic gv(int idx);
        logic [2:0] g;
        g = {damp_gate, sync_gate, main_gate};
        return g[idx];
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_len(input int idx, input logic val, output int n);
        n = 1;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (gv(idx) != val) break;
            n++;
        end
    endtask

    always @(negedge clk) begin
        if (!rst && ((main_gate && sync_gate) || (damp_gate && (main_gate || sync_gate))))
            overlap_seen++;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        int lat;
        rst = 1'b1; en = 1'b0; fb_low = 1'b0; ilim_trip = 1'b0; zero_cur = 1'b0;
        repeat (4) @(negedge clk);
        chk({main_gate, sync_gate, damp_gate} == 3'b000, "R1 reset", {main_gate, sync_gate, damp_gate}, 0);
        rst = 1'b0;
        en  = 1'b1;
        @(negedge clk);
        chk({main_gate, sync_gate, damp_gate} == 3'b000, "R1 after reset", {main_gate, sync_gate, damp_gate}, 0);

        // R2: no request, no switching
        n = 0;
        repeat (12) begin
            @(negedge clk);
            if ({main_gate, sync_gate, damp_gate} != 3'b000) n++;
        end
        chk(n == 0, "R2 idle without request", n, 0);

        // R2: request latency
        fb_low = 1'b1;
        lat = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            lat++;
            if (main_gate) break;
        end
        chk(lat == 3, "R2 start latency", lat, 3);

        // continuous conduction: R3 R5 R6 R7
        for (int p = 0; p < 4; p++) begin
            int a, b, c, d;
            run_len(0, 1'b1, a);
            chk(a == TON, "R3 on width", a, TON);
            run_len(1, 1'b0, b);
            chk(b == DEAD, "R6 dead after main", b, DEAD);
            run_len(1, 1'b1, c);
            chk(c == TOFF - 2 * DEAD, "R7 rectifier width", c, TOFF - 2 * DEAD);
            run_len(0, 1'b0, d);
            chk(d == DEAD, "R7 dead before main", d, DEAD);
            chk(b + c + d == TOFF, "R5 off time ccm", b + c + d, TOFF);
        end

        // R4 sweep of trip instant
        for (int j = 0; j <= 8; j++) begin
            int w, lo;
            w = 1;
            for (int k = 0; k < j; k++) begin
                @(negedge clk);
                w++;
            end
            ilim_trip = 1'b1;
            for (int k = 0; k < 50; k++) begin
                @(negedge clk);
                if (!main_gate) break;
                w++;
            end
            ilim_trip = 1'b0;
            chk(w == j + 3, "R4 trip width", w, j + 3);
            run_len(0, 1'b0, lo);
            chk(lo == TOFF, "R5 off after trip", lo, TOFF);
        end

        // R4/R5: trip held high
        ilim_trip = 1'b1;
        run_len(0, 1'b1, n);
        for (int p = 0; p < 3; p++) begin
            int lo, hi;
            run_len(0, 1'b0, lo);
            chk(lo == TOFF, "R5 off with held trip", lo, TOFF);
            run_len(0, 1'b1, hi);
            chk(hi == 1, "R4 held trip width", hi, 1);
        end
        ilim_trip = 1'b0;
        run_len(0, 1'b0, n);

        // discontinuous conduction: R8 R9
        for (int j = 0; j <= 4; j++) begin
            int a, b, w, hold, tail, g;
            fb_low = 1'b0;
            run_len(0, 1'b1, a);
            chk(a == TON, "R3 on width dcm", a, TON);
            run_len(1, 1'b0, b);
            chk(b == DEAD, "R6 dead after main dcm", b, DEAD);
            w = 1;
            for (int k = 0; k < j; k++) begin
                @(negedge clk);
                w++;
            end
            zero_cur = 1'b1;
            for (int k = 0; k < 50; k++) begin
                @(negedge clk);
                if (!sync_gate) break;
                w++;
            end
            chk(w == j + 3, "R8 zero-current turn-off", w, j + 3);
            chk(damp_gate == 1'b1, "R9 damp on with rectifier off", damp_gate, 1);
            zero_cur = 1'b0;
            hold = 0;
            repeat (10) begin
                @(negedge clk);
                if (damp_gate && !main_gate && !sync_gate) hold++;
            end
            chk(hold == 10, "R9 damp holds without request", hold, 10);
            fb_low = 1'b1;
            tail = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (!damp_gate) break;
                tail++;
            end
            chk(tail == 2, "R9 damp release latency", tail, 2);
            run_len(0, 1'b0, g);
            chk(g == DEAD, "R9 gap damp to main", g, DEAD);
        end

        // R10: shutdown during main pulse
        en = 1'b0;
        repeat (3) @(negedge clk);
        chk({main_gate, sync_gate, damp_gate} == 3'b000, "R10 off after en low", {main_gate, sync_gate, damp_gate}, 0);
        n = 0;
        repeat (20) begin
            @(negedge clk);
            if ({main_gate, sync_gate, damp_gate} != 3'b000) n++;
        end
        chk(n == 0, "R10 stays off in shutdown", n, 0);
        en = 1'b1;
        lat = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            lat++;
            if (main_gate) break;
        end
        chk(lat == 3, "R10 restart latency", lat, 3);

        // R10: shutdown during damping
        fb_low = 1'b0;
        run_len(0, 1'b1, n);
        run_len(1, 1'b0, n);
        zero_cur = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (damp_gate) break;
        end
        zero_cur = 1'b0;
        chk(damp_gate == 1'b1, "R9 damp reached", damp_gate, 1);
        en = 1'b0;
        repeat (3) @(negedge clk);
        chk(damp_gate == 1'b0, "R10 damp off in shutdown", damp_gate, 0);
        en = 1'b1;
        n = 0;
        repeat (12) begin
            @(negedge clk);
            if ({main_gate, sync_gate, damp_gate} != 3'b000) n++;
        end
        chk(n == 0, "R10 idle after re-enable", n, 0);

        chk(overlap_seen == 0, "R11 gate exclusivity", overlap_seen, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule